// File: doc/BRIEF.md
# Five-Stage Pipeline Interlock

This unit decides, every cycle, which stages of an in-order five-stage pipeline (fetch, decode, execute, memory, write-back) may advance. The pipeline has no operand forwarding, and one memory port serves both instruction fetch and data access. The unit compares the decode stage's source registers with the destinations of the instructions still in flight, and it checks which stages want the memory port. It then holds the younger instructions until each conflict has cleared.

The logic is combinational. For every stage it drives a stall (hold your contents) and a bubble (load an empty slot instead of the entry from behind). The clock and reset inputs only sample the embedded checks. The register file is taken to write in the first half of the write-back cycle, so the decode stage can read a value in the same cycle that value is written.

Top module: `pipe_interlock`

## Requirements
- R1: When every stage is invalid, the unit asserts no stall and no bubble.
- R2: If fetch (stage 0) requests the port while a valid older stage also requests it, fetch is stalled and a bubble is inserted into decode (`bubble_o[1]`).
- R3: The port goes to the oldest valid requester, where a higher stage index means older. That requester is never stalled for the port, and at most one valid requester is left unstalled.
- R4: If decode (stage 1) is valid and either of its sources equals the destination of a valid execute or memory instruction, that instruction has its write enabled, and the destination is nonzero, then decode and fetch stall and a bubble is inserted into execute.
- R5: A producer that has reached write-back causes no stall.
- R6: Register 0, an invalid producer, or a producer with its write disabled never causes a stall.
- R7: When the consumer immediately follows its producer, decode is held for exactly two cycles.
- R8: A stall in any stage also stalls every younger stage. No stage is stalled by a younger one, and write-back is never stalled.
- R9: `bubble_o[s]` is 1 exactly when stage s-1 is stalled and stage s is not. `bubble_o[0]` is always 0.
- R10: When port conflicts and register dependencies occur together, the older instruction proceeds first, and the final register contents match strict sequential execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock for the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset of the checks |
| valid_i | input | NSTG | Per-stage valid; index 0 = fetch, NSTG-1 = write-back |
| mem_req_i | input | NSTG | Per-stage request for the shared memory port |
| rd_a_i | input | RW | Decode stage first source register |
| rd_b_i | input | RW | Decode stage second source register |
| wr_en_i | input | NSTG-3 | Write enable of stages 2..NSTG-2 (index k = stage 2+k) |
| wr_reg_i | input | (NSTG-3)*RW | Destination register of stages 2..NSTG-2 |
| stall_o | output | NSTG | Per-stage hold |
| bubble_o | output | NSTG | Per-stage empty-slot insert |

## Verification
The bench targets four kinds of corner case:

- **Same-cycle write-back.** A producer in write-back must not cause a stall. A design that stalled here would only cost throughput, but a design that forgot the memory stage as a producer would read a stale register, which shows up in the final register compare.
- **Register 0 and disabled writes.** A design that matched register 0 or a disabled write would add spurious stall cycles.
- **Combined conflicts.** When a load in the memory stage and a decode dependency occur together, a wrong priority would stall the memory stage itself.
- **Back-to-back dependent pair.** This pair must produce exactly two decode stall cycles. An off-by-one in the producer range would give one or three.

// File: rtl/pipe_ilk_pkg.sv
package pipe_ilk_pkg;
  localparam int unsigned DEF_NSTG = 5;
  localparam int unsigned DEF_RW   = 5;
  localparam int unsigned STG_IF   = 0;
  localparam int unsigned STG_ID   = 1;
endpackage

// File: rtl/pipe_ilk_raw.sv
module pipe_ilk_raw #(
  parameter int unsigned NPROD = 2,
  parameter int unsigned RW    = 5
) (
  input  logic                      cons_valid_i,
  input  logic [RW-1:0]             rd_a_i,
  input  logic [RW-1:0]             rd_b_i,
  input  logic [NPROD-1:0]          prod_valid_i,
  input  logic [NPROD-1:0]          prod_wen_i,
  input  logic [NPROD-1:0][RW-1:0]  prod_reg_i,
  output logic                      hit_o
);
  logic [NPROD-1:0] match;

  for (genvar k = 0; k < NPROD; k++) begin : g_prod
    logic live;
    assign live     = prod_valid_i[k] && prod_wen_i[k] && (prod_reg_i[k] != '0);
    assign match[k] = live && ((prod_reg_i[k] == rd_a_i) || (prod_reg_i[k] == rd_b_i));
  end

  assign hit_o = cons_valid_i && (|match);
endmodule

// File: rtl/pipe_ilk_arb.sv
module pipe_ilk_arb #(
  parameter int unsigned NSTG = 5
) (
  input  logic [NSTG-1:0] req_i,
  output logic [NSTG-1:0] deny_o
);
  logic older;

  // higher index = older instruction = higher priority
  always_comb begin
    older = 1'b0;
    for (int s = NSTG - 1; s >= 0; s--) begin
      deny_o[s] = req_i[s] && older;
      older     = older || req_i[s];
    end
  end
endmodule

// File: rtl/pipe_ilk_chain.sv
module pipe_ilk_chain #(
  parameter int unsigned NSTG = 5
) (
  input  logic [NSTG-1:0] hold_i,
  output logic [NSTG-1:0] stall_o,
  output logic [NSTG-1:0] bubble_o
);
  logic acc;

  always_comb begin
    acc = 1'b0;
    for (int s = NSTG - 1; s >= 0; s--) begin
      acc        = acc || hold_i[s];
      stall_o[s] = acc;
    end
  end

  always_comb begin
    bubble_o[0] = 1'b0;
    for (int s = 1; s < NSTG; s++) begin
      bubble_o[s] = stall_o[s-1] && !stall_o[s];
    end
  end
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_ilk_pkg::*;
#(
  parameter int unsigned NSTG = DEF_NSTG,
  parameter int unsigned RW   = DEF_RW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NSTG-1:0]            valid_i,
  input  logic [NSTG-1:0]            mem_req_i,
  input  logic [RW-1:0]              rd_a_i,
  input  logic [RW-1:0]              rd_b_i,
  input  logic [NSTG-4:0]            wr_en_i,
  input  logic [NSTG-4:0][RW-1:0]    wr_reg_i,
  output logic [NSTG-1:0]            stall_o,
  output logic [NSTG-1:0]            bubble_o
);
  localparam int unsigned NPROD  = NSTG - 3;
  localparam int unsigned P_LO   = STG_ID + 1;
  localparam int unsigned STG_WB = NSTG - 1;

  logic [NSTG-1:0] port_req, port_deny, hold;
  logic            raw_hit;

  assign port_req = valid_i & mem_req_i;

  pipe_ilk_arb #(.NSTG(NSTG)) u_arb (
    .req_i  (port_req),
    .deny_o (port_deny)
  );

  // write-back excluded: register file writes before decode reads
  pipe_ilk_raw #(.NPROD(NPROD), .RW(RW)) u_raw (
    .cons_valid_i (valid_i[STG_ID]),
    .rd_a_i       (rd_a_i),
    .rd_b_i       (rd_b_i),
    .prod_valid_i (valid_i[P_LO +: NPROD]),
    .prod_wen_i   (wr_en_i),
    .prod_reg_i   (wr_reg_i),
    .hit_o        (raw_hit)
  );

  always_comb begin
    hold         = port_deny;
    hold[STG_ID] = port_deny[STG_ID] || raw_hit;
  end

  pipe_ilk_chain #(.NSTG(NSTG)) u_chain (
    .hold_i   (hold),
    .stall_o  (stall_o),
    .bubble_o (bubble_o)
  );

  p_raw_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_hit |-> (stall_o[STG_ID] && stall_o[STG_IF]));

  p_fetch_yields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_req[STG_IF] && (|port_req[NSTG-1:1])) |-> stall_o[STG_IF]);

  p_one_port_user_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_req & ~stall_o));

  p_wb_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o[STG_WB]);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i == '0) |-> ((stall_o == '0) && (bubble_o == '0)));

  for (genvar s = 0; s < NSTG - 1; s++) begin : g_chk
    p_chain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o[s+1] |-> stall_o[s]);
    p_bubble_fetch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bubble_o[s+1] |-> stall_o[STG_IF]);
  end
endmodule

// File: tb/pipe_interlock_tb.sv
`timescale 1ns/1ps
module pipe_interlock_tb;
  localparam int NS = 5;
  localparam int RW = 3;
  localparam int NR = 8;
  localparam int NP = NS - 3;
  localparam int MAXP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] v = '0, mr = '0;
  logic [RW-1:0] ra = '0, rb = '0;
  logic [NP-1:0] wen = '0;
  logic [NP-1:0][RW-1:0] wreg = '0;
  logic [NS-1:0] stall, bub;

  always #2.5 clk = ~clk;

  pipe_interlock #(.NSTG(NS), .RW(RW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v), .mem_req_i(mr),
    .rd_a_i(ra), .rd_b_i(rb), .wr_en_i(wen), .wr_reg_i(wreg),
    .stall_o(stall), .bubble_o(bub)
  );

  int errs = 0, chks = 0;

  int p_d[MAXP], p_a[MAXP], p_b[MAXP], p_en[MAXP], p_mem[MAXP], p_imm[MAXP];
  int plen = 0;
  int st[NS];
  int res[NS];
  int unsigned rf[NR], rf_ref[NR];

  task automatic clear_in();
    v = '0; mr = '0; ra = '0; rb = '0; wen = '0; wreg = '0;
  endtask

  function automatic void expect_calc(output logic [NS-1:0] es, output logic [NS-1:0] eb);
    logic [NS-1:0] hold;
    logic raw;
    raw = 1'b0;
    for (int k = 0; k < NP; k++)
      if (v[1] && v[2+k] && wen[k] && wreg[k] != 0 && (wreg[k] == ra || wreg[k] == rb))
        raw = 1'b1;
    for (int s = 0; s < NS; s++) begin
      logic conf;
      conf = 1'b0;
      for (int o = s + 1; o < NS; o++)
        if (v[s] && mr[s] && v[o] && mr[o]) conf = 1'b1;
      hold[s] = conf || (s == 1 && raw);
    end
    for (int s = 0; s < NS; s++) begin
      es[s] = 1'b0;
      for (int t = s; t < NS; t++) if (hold[t]) es[s] = 1'b1;
    end
    for (int s = 0; s < NS; s++) eb[s] = (s > 0) && es[s-1] && !es[s];
  endfunction

  task automatic check_outs(string req);
    logic [NS-1:0] es, eb;
    #1;
    expect_calc(es, eb);
    chks++;
    if (stall !== es || bub !== eb) begin
      errs++;
      $display("FAIL %s stall=%b exp=%b bubble=%b exp=%b", req, stall, es, bub, eb);
    end
  endtask

  task automatic add_instr(int d, int en, int a, int b, int imm, int mem);
    p_d[plen] = d; p_en[plen] = en; p_a[plen] = a; p_b[plen] = b;
    p_imm[plen] = imm; p_mem[plen] = mem; plen++;
  endtask

  task automatic drive_model();
    clear_in();
    for (int s = 0; s < NS; s++) if (st[s] >= 0) begin
      v[s] = 1'b1;
      if (s == 0) mr[s] = 1'b1;
      if (s == 3) mr[s] = p_mem[st[s]] != 0;
      if (s == 1) begin ra = RW'(p_a[st[s]]); rb = RW'(p_b[st[s]]); end
      if (s >= 2 && s <= NS - 2) begin
        wen[s-2]  = p_en[st[s]] != 0;
        wreg[s-2] = RW'(p_d[st[s]]);
      end
    end
  endtask

  // runs program, checks every cycle, compares final register file
  task automatic run_prog(string req, output int id_stalls, output int if_stalls);
    int pc, cyc, nres;
    bit busy;
    id_stalls = 0; if_stalls = 0;
    for (int r = 0; r < NR; r++) begin rf[r] = 0; rf_ref[r] = 0; end
    for (int s = 0; s < NS; s++) begin st[s] = -1; res[s] = 0; end
    pc = 0;
    if (plen > 0) st[0] = 0;
    cyc = 0;
    busy = 1'b1;
    while (busy && cyc < 2000) begin
      @(negedge clk);
      drive_model();
      check_outs(req);
      if (stall[1] && v[1]) id_stalls++;
      if (stall[0] && v[0]) if_stalls++;
      @(posedge clk);
      if (st[NS-1] >= 0 && p_en[st[NS-1]] != 0 && p_d[st[NS-1]] != 0)
        rf[p_d[st[NS-1]]] = res[NS-1];
      nres = 0;
      if (st[1] >= 0) nres = int'(rf[p_a[st[1]]] + rf[p_b[st[1]]]) + p_imm[st[1]];
      for (int s = NS - 1; s >= 1; s--) if (!stall[s]) begin
        if (stall[s-1]) st[s] = -1;
        else begin
          st[s]  = st[s-1];
          res[s] = (s == 2) ? nres : res[s-1];
        end
      end
      if (!stall[0]) begin
        if (st[0] >= 0) pc++;
        st[0] = (pc < plen) ? pc : -1;
      end
      busy = 1'b0;
      for (int s = 0; s < NS; s++) if (st[s] >= 0) busy = 1'b1;
      cyc++;
    end
    for (int i = 0; i < plen; i++)
      if (p_en[i] != 0 && p_d[i] != 0)
        rf_ref[p_d[i]] = rf_ref[p_a[i]] + rf_ref[p_b[i]] + p_imm[i];
    for (int r = 0; r < NR; r++) begin
      chks++;
      if (rf[r] !== rf_ref[r]) begin
        errs++;
        $display("FAIL R10 %s reg%0d got=%0d exp=%0d", req, r, rf[r], rf_ref[r]);
      end
    end
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; chks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    int ids, ifs, dummy;
    dummy = $urandom(32'h5EED1);
    clear_in();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    clear_in(); check_outs("R1");

    // R4: EX producer of ra
    clear_in(); v = 5'b00110; ra = 3; wen[0] = 1; wreg[0] = 3; check_outs("R4");
    // R4: MEM producer of rb
    clear_in(); v = 5'b01011; rb = 5; wen[1] = 1; wreg[1] = 5; check_outs("R4");
    // R5: producer already in write-back
    clear_in(); v = 5'b10011; ra = 2; check_outs("R5");
    // R6: register 0, disabled write, invalid producer
    clear_in(); v = 5'b00110; ra = 0; wen[0] = 1; wreg[0] = 0; check_outs("R6");
    clear_in(); v = 5'b00110; ra = 4; wen[0] = 0; wreg[0] = 4; check_outs("R6");
    clear_in(); v = 5'b00010; ra = 4; wen[0] = 1; wreg[0] = 4; check_outs("R6");
    // R2: load in MEM blocks fetch
    clear_in(); v = 5'b01001; mr = 5'b01001; check_outs("R2");
    // R3: three requesters, oldest wins
    clear_in(); v = 5'b01101; mr = 5'b01101; check_outs("R3");
    // R10: port conflict plus dependency together
    clear_in(); v = 5'b01111; mr = 5'b01001; ra = 1; wen[1] = 1; wreg[1] = 1; check_outs("R10");
    // R8: invalid stages do not stall
    clear_in(); v = 5'b10000; mr = 5'b11111; check_outs("R8");

    plen = 0;
    add_instr(1, 1, 0, 0, 5, 0);
    add_instr(2, 1, 1, 0, 1, 0);
    run_prog("R7", ids, ifs);
    chks++;
    if (ids != 2) begin errs++; $display("FAIL R7 decode stall cycles got=%0d exp=2", ids); end

    plen = 0;
    add_instr(1, 1, 0, 0, 3, 1);
    add_instr(2, 1, 0, 0, 4, 0);
    add_instr(3, 1, 0, 0, 6, 0);
    add_instr(4, 1, 0, 0, 7, 0);
    add_instr(5, 1, 0, 0, 8, 0);
    run_prog("R2", ids, ifs);
    chks++;
    if (ifs != 1) begin errs++; $display("FAIL R2 fetch stall cycles got=%0d exp=1", ifs); end

    for (int n = 0; n < 6; n++) begin
      plen = 0;
      for (int i = 0; i < 40; i++)
        add_instr(int'($urandom % NR), int'(($urandom % 4) != 0), int'($urandom % NR),
                  int'($urandom % NR), int'($urandom % 256), int'(($urandom % 4) == 0));
      run_prog("R9", ids, ifs);
    end

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule